// File: doc/BRIEF.md
# I2C Bus Recovery Pulse Generator

This block frees an I2C bus that a target has left stuck, for example after a master reset in the middle of a read. A target that is still shifting out a byte will hold SDA low. Clocking it a fixed number of times with SDA released lets it finish that byte and see a not-acknowledge, and it then returns to idle. A one-cycle request on `start_i` launches the sequence. The block first leaves both lines released for one quarter-period. It then issues a train of SCL pulses with SDA left released, and closes with a full STOP condition built from four quarter-period phases. After the STOP, both lines are released again.

Both lines are driven as open-drain enables: a `1` on an enable output pulls that line low, and a `0` releases it so the external pull-up takes it high. All timing comes from a quarter-period counted in system clock cycles (`QTR_CYCLES`). The default is a 5 µs quarter at a 100 MHz clock, which gives a bus clock of about 50 kHz. `busy_o` covers the whole sequence. `done_o` marks its end for a single cycle.

Top module: `bus_unstick_gen`

## Requirements
- R1: Out of reset and whenever idle, `scl_oe_o` and `sda_oe_o` are 0 (both lines released), `busy_o` is 0, and `done_o` is 0 except in the single cycle given by R6.
- R2: When `start_i` is 1 in an idle cycle, `busy_o` is 1 from the next cycle on. The first quarter-period of the run keeps both enables at 0.
- R3: After that quarter, exactly `PULSES` (default 9) SCL pulses follow. Each pulse is two quarters with `scl_oe_o`=1 and then two quarters with `scl_oe_o`=0. `sda_oe_o` stays 0 for the whole train.
- R4: After the last pulse, a STOP follows in four quarters, in this order: `scl_oe_o`=1 with `sda_oe_o`=0; then both enables at 1; then `scl_oe_o`=0 with `sda_oe_o`=1; then both enables at 0.
- R5: Every quarter lasts exactly `QTR_CYCLES` clock cycles, so `busy_o` stays 1 for exactly (4·`PULSES`+5)·`QTR_CYCLES` consecutive cycles.
- R6: In the cycle right after the last busy cycle, `done_o` is 1 for exactly one cycle, `busy_o` is 0 and both enables are 0.
- R7: `start_i` while `busy_o` is 1 has no effect. The run continues unchanged, and its length and waveform are the same as those of an undisturbed run.
- R8: A `start_i` in the cycle where `done_o` is 1 is accepted, because the block is already idle in that cycle. A new run begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a recovery sequence |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Every cycle, the bench compares both enables, `busy_o` and `done_o` against a quarter-indexed reference waveform. That comparison separates an off-by-one quarter length, a miscounted pulse train and a misordered STOP phase. One directed run with a quiet `start_i` sets the baseline. Runs with random idle gaps and random `start_i` noise during the sequence show whether a busy-time request restarts or shortens a run. A request held high across the `done_o` cycle separates a design that accepts back-to-back runs from one that loses the idle cycle.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

    // Sequence phases; each non-idle phase lasts whole quarter-periods.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PREP,
        PH_CLK_LO,
        PH_CLK_HI,
        PH_STP_SCL,
        PH_STP_SDA,
        PH_STP_RISE,
        PH_STP_END
    } unstick_phase_e;

endpackage

// File: rtl/bus_unstick_qtimer.sv
module bus_unstick_qtimer #(
    parameter int QTR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i || tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick_o = run_i && (tmr_q.cnt == LAST);

endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
    import bus_unstick_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           tick_i,
    output unstick_phase_e phase_o,
    output logic           done_o
);
    localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [PW-1:0] LAST_PULSE = PW'(PULSES - 1);

    typedef struct packed {
        unstick_phase_e phase;
        logic           sub;    // second quarter of a two-quarter half-pulse
        logic [PW-1:0]  pulse;
        logic           done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_PREP;
                    seq_d.sub   = 1'b0;
                    seq_d.pulse = '0;
                end
            end
            PH_PREP: begin
                if (tick_i) seq_d.phase = PH_CLK_LO;
            end
            PH_CLK_LO: begin
                if (tick_i) begin
                    seq_d.sub = ~seq_q.sub;
                    if (seq_q.sub) seq_d.phase = PH_CLK_HI;
                end
            end
            PH_CLK_HI: begin
                if (tick_i) begin
                    seq_d.sub = ~seq_q.sub;
                    if (seq_q.sub) begin
                        if (seq_q.pulse == LAST_PULSE) begin
                            seq_d.phase = PH_STP_SCL;
                        end else begin
                            seq_d.pulse = seq_q.pulse + 1'b1;
                            seq_d.phase = PH_CLK_LO;
                        end
                    end
                end
            end
            PH_STP_SCL: begin
                if (tick_i) seq_d.phase = PH_STP_SDA;
            end
            PH_STP_SDA: begin
                if (tick_i) seq_d.phase = PH_STP_RISE;
            end
            PH_STP_RISE: begin
                if (tick_i) seq_d.phase = PH_STP_END;
            end
            PH_STP_END: begin
                if (tick_i) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, sub: 1'b0, pulse: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign done_o  = seq_q.done;

endmodule

// File: rtl/bus_unstick_lines.sv
module bus_unstick_lines
    import bus_unstick_pkg::*;
(
    input  unstick_phase_e phase_i,
    output logic           scl_oe_o,
    output logic           sda_oe_o
);
    always_comb begin
        scl_oe_o = 1'b0;
        sda_oe_o = 1'b0;
        unique case (phase_i)
            PH_CLK_LO:   scl_oe_o = 1'b1;
            PH_STP_SCL:  scl_oe_o = 1'b1;
            PH_STP_SDA: begin
                scl_oe_o = 1'b1;
                sda_oe_o = 1'b1;
            end
            PH_STP_RISE: sda_oe_o = 1'b1;
            default: begin
                scl_oe_o = 1'b0;
                sda_oe_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bus_unstick_gen.sv
module bus_unstick_gen
    import bus_unstick_pkg::*;
#(
    parameter int QTR_CYCLES = 500,  // 5 us quarter at 100 MHz
    parameter int PULSES     = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o
);
    unstick_phase_e phase;
    logic           tick;

    assign busy_o = (phase != PH_IDLE);

    bus_unstick_qtimer #(.QTR_CYCLES(QTR_CYCLES)) u_qtimer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    bus_unstick_seq #(.PULSES(PULSES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .tick_i  (tick),
        .phase_o (phase),
        .done_o  (done_o)
    );

    bus_unstick_lines u_lines (
        .phase_i  (phase),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o)
    );

endmodule

// File: rtl/bus_unstick_checker.sv
module bus_unstick_checker #(
    parameter int QTR_CYCLES = 500,
    parameter int PULSES     = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_oe_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o
);
    localparam int RUN_CYCLES = (4 * PULSES + 5) * QTR_CYCLES;

    int   len_q;
    int   lows_q;
    logic scl_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q      <= 0;
            lows_q     <= 0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_oe_o;
            len_q      <= busy_o ? len_q + 1 : 0;
            lows_q     <= busy_o ? lows_q + int'(scl_oe_o && !scl_prev_q) : 0;
        end
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    a_r3_sda_free_on_scl_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> scl_oe_o);

    a_r4_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_oe_o);

    a_r3_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lows_q == PULSES + 1));

    a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_q == RUN_CYCLES));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    a_r7_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind bus_unstick_gen bus_unstick_checker #(
    .QTR_CYCLES (QTR_CYCLES),
    .PULSES     (PULSES)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/bus_unstick_gen_tb.sv
`timescale 1ns/1ps
module bus_unstick_gen_tb;
    localparam int Q   = 3;
    localparam int P   = 9;
    localparam int RUN = (4 * P + 5) * Q;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_oe_o, sda_oe_o, busy_o, done_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    bus_unstick_gen #(.QTR_CYCLES(Q), .PULSES(P)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    // Reference position in the run: -1 idle, else cycle index within the run.
    int   m_idx = -1;
    logic m_done = 1'b0;
    logic spam_seen = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx     <= -1;
            m_done    <= 1'b0;
            spam_seen <= 1'b0;
        end else begin
            m_done    <= (m_idx == RUN - 1);
            spam_seen <= start_i && (m_idx >= 0) && (m_idx < RUN - 1);
            if (m_idx < 0)             m_idx <= start_i ? 0 : -1;
            else if (m_idx == RUN - 1) m_idx <= -1;
            else                       m_idx <= m_idx + 1;
        end
    end

    function automatic logic exp_scl(int idx);
        int k;
        if (idx < 0) return 1'b0;
        k = idx / Q;
        if (k == 0) return 1'b0;
        if (k <= 4 * P) return ((k - 1) % 4) < 2;
        return (k - 4 * P == 1) || (k - 4 * P == 2);
    endfunction

    function automatic logic exp_sda(int idx);
        int k;
        if (idx < 0) return 1'b0;
        k = idx / Q;
        return (k - 4 * P == 2) || (k - 4 * P == 3);
    endfunction

    function automatic string tag_of(int idx, logic dn);
        int k;
        if (idx < 0) return dn ? "R6" : "R1";
        k = idx / Q;
        if (k == 0) return "R2";
        if (k <= 4 * P) return "R3";
        return "R4";
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    task automatic chk_int(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle waveform comparison away from the active edge.
    int blen = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string t;
            t = tag_of(m_idx, m_done);
            chk(t, "scl_oe", scl_oe_o, exp_scl(m_idx));
            chk(t, "sda_oe", sda_oe_o, exp_sda(m_idx));
            chk(t, "busy", busy_o, m_idx >= 0);
            chk(t, "done", done_o, m_done);
            if (spam_seen) chk("R7", "busy after ignored start", busy_o, 1'b1);
            if (busy_o) blen++;
            else begin
                if (done_o) chk_int("R5", "busy length", blen, RUN);
                blen = 0;
            end
        end
    end

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1", "reset scl_oe", scl_oe_o, 1'b0);
        chk("R1", "reset sda_oe", sda_oe_o, 1'b0);
        chk("R1", "reset busy", busy_o, 1'b0);
        chk("R1", "reset done", done_o, 1'b0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "idle without request", busy_o, 1'b0);

        // Directed: one quiet run.
        #1 start_i = 1'b1;
        @(negedge clk);
        #1 start_i = 1'b0;
        chk("R2", "busy after start", busy_o, 1'b1);
        wait_done();
        @(negedge clk);

        // Directed R8: start held high across the done cycle.
        #1 start_i = 1'b1;
        wait_done();
        @(negedge clk);
        chk("R8", "restart after done cycle", busy_o, 1'b1);
        #1 start_i = 1'b0;
        wait_done();
        repeat (2) @(negedge clk);

        // Random runs: random gaps, random request noise while busy.
        for (int r = 0; r < 24; r++) begin
            int gap;
            int noise;
            gap   = int'($urandom_range(0, 6));
            noise = int'($urandom_range(0, 3));
            repeat (gap) @(negedge clk);
            #1 start_i = 1'b1;
            @(negedge clk);
            #1 start_i = 1'b0;
            while (!done_o) begin
                @(negedge clk);
                #1 start_i = (noise != 0) && ($urandom_range(0, 7) < noise);
            end
            #0 start_i = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule